// File: doc/BRIEF.md
# Triggered L1 Pop Window Controller

This block drains a zero-suppressed level-1 FIFO whose word stream carries periodic roll-over marker words between hit words. A free-running write-side stamp counter advances every clock. A read-side pointer advances only when a popped word is a marker, so the read side is tracked in marker time and not by address. After reset the block waits until the stamp has moved more than a fixed latency ahead of the pointer. From then on it pops whenever the lag exceeds that latency, which throws old data away at the rate it ages.

When a level-1 trigger strobe arrives while the block is following, popping stops and the pointer value is latched. The block then waits for a daisy-chain readout token. When the token comes it pops again, and it forwards every popped hit word to an event buffer. It stops once the pointer has advanced one window length past the latched value. It then sends a one-cycle token to the next block in the chain and goes back to following. The FIFO is read in show-ahead mode: the head word is presented with an empty flag, and `pop_o` consumes it in the same cycle.

Top module: `tpw_l1_pop_ctrl`

## Requirements
- R1: While reset is asserted and afterwards in the wait state, `pop_o`, `push_o` and `tok_out_o` are low. The wait state is left only when the lag (stamp minus pointer, modulo 2^TS_W) exceeds LAT.
- R2: The stamp starts at 0 after reset and advances by one every clock. The first pop therefore comes LAT+2 clock edges after reset is released, provided the FIFO holds data.
- R3: In the follow state, `pop_o` is high exactly when the FIFO is not empty, the lag is greater than LAT and no trigger is present in that cycle.
- R4: A popped word with bit DATA_W-1 set is a marker and advances the pointer by 2^MARK_SHIFT stamp counts. Hit words (bit DATA_W-1 clear) leave the pointer unchanged. A complete window therefore consumes WIN/2^MARK_SHIFT markers.
- R5: A trigger in the follow state suppresses the pop in that cycle and latches the pointer. No pops occur after that until a token arrives.
- R6: In the window state, the block pops whenever the FIFO is not empty and the pointer minus the latched value is below WIN. Each popped hit word is pushed with `push_word_o` equal to the popped word. A marker is never pushed (default KEEP_MARK=0).
- R7: When the pointer minus the latched value reaches WIN in the window state, `tok_out_o` is high for exactly one cycle and the block returns to following. One token goes out per token accepted.
- R8: A trigger outside the follow state and a token outside the hold state are ignored. The pop sequence is the same as it would be without them.
- R9: `pop_o` is never high while `lvl_empty_i` is high.
- R10: All lag and window differences are taken modulo 2^TS_W. Following and windowing continue correctly after the stamp wraps past 2^TS_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Level-1 trigger strobe |
| tok_in_i | input | 1 | Readout token from the previous block in the chain |
| lvl_empty_i | input | 1 | FIFO empty flag |
| rd_word_i | input | DATA_W | FIFO head word (show-ahead); bit DATA_W-1 set marks a roll-over marker |
| pop_o | output | 1 | Consume the FIFO head word this cycle |
| push_o | output | 1 | Write `push_word_o` to the event buffer |
| push_word_o | output | DATA_W | Event-buffer write data |
| tok_out_o | output | 1 | One-cycle token to the next block in the chain |

## Verification
`pop_o`, `push_o`, `push_word_o` and `tok_out_o` are combinational from the state registers and the current inputs. Each one is therefore due in the same cycle as the inputs it depends on. The effect of a trigger, token or popped marker shows up one edge later. The bench drives inputs on the falling edge, compares all four outputs with a behavioural model shortly after, and only then advances the model by one edge, so every comparison lands in the cycle the result is due. The first-pop cycle is checked against LAT+2 edges after reset release, and the marker count per window against WIN/2^MARK_SHIFT.

// File: rtl/tpw_pkg.sv
package tpw_pkg;

   typedef enum logic [1:0] {
      PW_WAIT   = 2'd0,
      PW_FOLLOW = 2'd1,
      PW_HOLD   = 2'd2,
      PW_WINDOW = 2'd3
   } pw_state_e;

endpackage

// File: rtl/tpw_stamp.sv
module tpw_stamp #(
   parameter int TS_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] stamp_o
);

   logic [TS_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign stamp_o = cnt_q;

endmodule

// File: rtl/tpw_mark_ptr.sv
module tpw_mark_ptr #(
   parameter int TS_W       = 12,
   parameter int MARK_SHIFT = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv_i,
   input  logic            latch_i,
   output logic [TS_W-1:0] ptr_o,
   output logic [TS_W-1:0] held_o
);

   localparam int HI_W = TS_W - MARK_SHIFT;

   logic [HI_W-1:0] ptr_q;
   logic [HI_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         held_q <= '0;
      end else begin
         if (adv_i)   ptr_q  <= ptr_q + 1'b1;
         if (latch_i) held_q <= ptr_q;
      end
   end

   generate
      if (MARK_SHIFT > 0) begin : g_scaled
         assign ptr_o  = {ptr_q,  {MARK_SHIFT{1'b0}}};
         assign held_o = {held_q, {MARK_SHIFT{1'b0}}};
      end else begin : g_unscaled
         assign ptr_o  = ptr_q;
         assign held_o = held_q;
      end
   endgenerate

endmodule

// File: rtl/tpw_seq.sv
module tpw_seq
   import tpw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lag_over_i,
   input  logic      win_done_i,
   input  logic      trig_i,
   input  logic      tok_in_i,
   output pw_state_e st_o
);

   pw_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PW_WAIT:   if (lag_over_i) st_d = PW_FOLLOW;
         PW_FOLLOW: if (trig_i)     st_d = PW_HOLD;
         PW_HOLD:   if (tok_in_i)   st_d = PW_WINDOW;
         PW_WINDOW: if (win_done_i) st_d = PW_FOLLOW;
         default:                   st_d = PW_WAIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= PW_WAIT;
      else        st_q <= st_d;
   end

   assign st_o = st_q;

endmodule

// File: rtl/tpw_l1_pop_ctrl.sv
module tpw_l1_pop_ctrl
   import tpw_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int TS_W       = 12,
   parameter int MARK_SHIFT = 4,
   parameter int LAT        = 1024,
   parameter int WIN        = 256,
   parameter int KEEP_MARK  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              tok_in_i,
   input  logic              lvl_empty_i,
   input  logic [DATA_W-1:0] rd_word_i,
   output logic              pop_o,
   output logic              push_o,
   output logic [DATA_W-1:0] push_word_o,
   output logic              tok_out_o
);

   localparam logic [TS_W-1:0] LAT_V = LAT[TS_W-1:0];
   localparam logic [TS_W-1:0] WIN_V = WIN[TS_W-1:0];
   localparam int              HALF  = 2 ** (TS_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_dw
         $error("DATA_W must be at least 2");
      end
      if (MARK_SHIFT < 0 || MARK_SHIFT >= TS_W) begin : g_bad_ms
         $error("MARK_SHIFT must lie in 0..TS_W-1");
      end
      if (LAT <= 0 || LAT >= HALF) begin : g_bad_lat
         $error("LAT must be positive and below half the stamp range");
      end
      if (WIN <= 0 || WIN >= HALF || (WIN % (2 ** MARK_SHIFT)) != 0) begin : g_bad_win
         $error("WIN must be a positive multiple of the marker period below half the stamp range");
      end
   endgenerate

   pw_state_e       st_q;
   logic [TS_W-1:0] stamp;
   logic [TS_W-1:0] ptr;
   logic [TS_W-1:0] held;
   logic [TS_W-1:0] lag;
   logic [TS_W-1:0] elapsed;
   logic            lag_over;
   logic            win_done;
   logic            is_mark;
   logic            take_trig;
   logic            pop_follow;
   logic            pop_window;

   tpw_stamp #(.TS_W(TS_W)) u_stamp (
      .clk     (clk),
      .rst_n   (rst_n),
      .stamp_o (stamp)
   );

   tpw_mark_ptr #(.TS_W(TS_W), .MARK_SHIFT(MARK_SHIFT)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (pop_o & is_mark),
      .latch_i (take_trig),
      .ptr_o   (ptr),
      .held_o  (held)
   );

   tpw_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .lag_over_i (lag_over),
      .win_done_i (win_done),
      .trig_i     (trig_i),
      .tok_in_i   (tok_in_i),
      .st_o       (st_q)
   );

   // modulo-2^TS_W differences
   assign lag      = stamp - ptr;
   assign elapsed  = ptr - held;
   assign lag_over = lag > LAT_V;
   assign win_done = elapsed >= WIN_V;
   assign is_mark  = rd_word_i[DATA_W-1];

   assign take_trig  = (st_q == PW_FOLLOW) && trig_i;
   assign pop_follow = (st_q == PW_FOLLOW) && lag_over && !trig_i;
   assign pop_window = (st_q == PW_WINDOW) && !win_done;

   assign pop_o       = !lvl_empty_i && (pop_follow || pop_window);
   assign tok_out_o   = (st_q == PW_WINDOW) && win_done;
   assign push_word_o = rd_word_i;

   generate
      if (KEEP_MARK != 0) begin : g_keep_mark
         assign push_o = pop_o && pop_window;
      end else begin : g_hits_only
         assign push_o = pop_o && pop_window && !is_mark;
      end
   endgenerate

endmodule

// File: rtl/tpw_l1_pop_ctrl_chk.sv
module tpw_l1_pop_ctrl_chk #(
   parameter int DATA_W    = 16,
   parameter int KEEP_MARK = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig_i,
   input logic              tok_in_i,
   input logic              lvl_empty_i,
   input logic [DATA_W-1:0] rd_word_i,
   input logic              pop_o,
   input logic              push_o,
   input logic              tok_out_o,
   input logic [1:0]        st
);

   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_empty_i |-> !pop_o); // R9

   AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 2'd0) |-> (!pop_o && !push_o && !tok_out_o)); // R1

   AST_TRIG_STOPS_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 2'd1 && trig_i) |-> !pop_o); // R5

   AST_HOLD_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 2'd1 && trig_i) |=> (!pop_o && st == 2'd2)); // R5

   AST_PUSH_WITH_POP: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> (pop_o && (KEEP_MARK != 0 || !rd_word_i[DATA_W-1]))); // R6

   AST_TOKEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tok_out_o |=> (!tok_out_o && st == 2'd1)); // R7

   AST_TOKEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 2'd1 && tok_in_i && !trig_i) |=> (st == 2'd1)); // R8

endmodule

bind tpw_l1_pop_ctrl tpw_l1_pop_ctrl_chk #(.DATA_W(DATA_W), .KEEP_MARK(KEEP_MARK)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .trig_i      (trig_i),
   .tok_in_i    (tok_in_i),
   .lvl_empty_i (lvl_empty_i),
   .rd_word_i   (rd_word_i),
   .pop_o       (pop_o),
   .push_o      (push_o),
   .tok_out_o   (tok_out_o),
   .st          (st_q)
);

// File: tb/sim_tpw_l1_pop_ctrl.sv
`timescale 1ns/1ps
module sim_tpw_l1_pop_ctrl;

   localparam int DW  = 16;
   localparam int TW  = 12;
   localparam int MS  = 4;
   localparam int LAT = 1024;
   localparam int WIN = 256;
   localparam int MOD = 4096;
   localparam int NCYC = 5000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0;
   logic          tok_in = 1'b0;
   logic          empty = 1'b1;
   logic [DW-1:0] word = '0;
   logic          pop, push, tok_out;
   logic [DW-1:0] push_word;

   always #2 clk = ~clk;

   tpw_l1_pop_ctrl #(.DATA_W(DW), .TS_W(TW), .MARK_SHIFT(MS), .LAT(LAT), .WIN(WIN)) u0 (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .tok_in_i(tok_in), .lvl_empty_i(empty),
      .rd_word_i(word), .pop_o(pop), .push_o(push), .push_word_o(push_word), .tok_out_o(tok_out)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural model
   logic [DW-1:0] fifo_q[$];
   int m_st = 0, m_ts = 0, m_tp = 0, m_held = 0, cyc = 0;
   int first_pop = -1, win_marks = 0, tok_acc = 0, tok_seen = 0, late_pops = 0, mark_no = 0;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
      end
   endtask

   function automatic bit trig_at(input int c);
      return c == 100 || c == 1500 || c == 1520 || c == 2500 || c == 3000 || c == 4300 || c == 4420;
   endfunction
   function automatic bit tok_at(input int c);
      return c == 200 || c == 1450 || c == 1550 || c == 2501 || c == 3005 || c == 4400;
   endfunction
   function automatic bit mask_at(input int c);
      return (c >= 1200 && c <= 1205) || (c >= 3010 && c <= 3020);
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      #1;
      chk(!pop && !push && !tok_out, "R1", "outputs in reset", {pop, push, tok_out}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < NCYC; c++) begin
         int  lag, el, ep, epush, etok;
         bit  emark;
         string tg;
         if (c > 0) @(negedge clk);
         trig   = trig_at(cyc);
         tok_in = tok_at(cyc);
         empty  = (fifo_q.size() == 0) || mask_at(cyc);
         word   = (fifo_q.size() != 0) ? fifo_q[0] : '0;
         #1;
         lag   = (m_ts - m_tp + MOD) % MOD;
         el    = (m_tp - m_held + MOD) % MOD;
         emark = word[DW-1];
         ep = 0;
         if (m_st == 1) ep = (!empty && lag > LAT && !trig) ? 1 : 0;
         if (m_st == 3) ep = (!empty && el < WIN) ? 1 : 0;
         epush = (m_st == 3 && ep == 1 && !emark) ? 1 : 0;
         etok  = (m_st == 3 && el >= WIN) ? 1 : 0;
         case (m_st)
            0: tg = "R1";
            1: tg = trig ? "R5" : (cyc > MOD ? "R10" : "R3");
            2: tg = "R5";
            default: tg = "R6";
         endcase
         if ((trig && m_st != 1) || (tok_in && m_st != 2)) tg = "R8";
         if (mask_at(cyc)) tg = "R9";
         chk(pop == ep[0], tg, "pop", pop, ep);
         chk(push == epush[0], "R6", "push", push, epush);
         if (epush == 1) chk(push_word == word, "R6", "push data", push_word, word);
         chk(tok_out == etok[0], "R7", "token out", tok_out, etok);
         // observations at the ports
         if (pop && first_pop < 0) first_pop = cyc;
         if (pop && cyc > MOD + 100) late_pops++;
         if (pop && word[DW-1] && m_st == 3) win_marks++;
         if (tok_out) begin
            tok_seen++;
            chk(win_marks == WIN >> MS, "R4", "markers per window", win_marks, WIN >> MS);
         end
         // advance model by one edge
         if (ep == 1) begin
            if (fifo_q[0][DW-1]) m_tp = (m_tp + (1 << MS)) % MOD;
            void'(fifo_q.pop_front());
         end
         case (m_st)
            0: if (lag > LAT) m_st = 1;
            1: if (trig) begin m_st = 2; m_held = m_tp; end
            2: if (tok_in) begin m_st = 3; tok_acc++; win_marks = 0; end
            default: if (el >= WIN) m_st = 1;
         endcase
         m_ts = (m_ts + 1) % MOD;
         if (cyc % 16 == 15) begin
            fifo_q.push_back({1'b1, 15'(mark_no)});
            mark_no++;
         end else if ($urandom_range(3) == 0) begin
            fifo_q.push_back({1'b0, 15'($urandom_range(32767))});
         end
         cyc++;
      end
      chk(first_pop == LAT + 2, "R2", "first pop cycle", first_pop, LAT + 2);
      chk(tok_seen == tok_acc && tok_acc == 4, "R7", "tokens out", tok_seen, 4);
      chk(late_pops > 0, "R10", "pops after stamp wrap", late_pops, 1);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule